// File: doc/BRIEF.md
# Branch Resolution and Link Unit

This unit settles the outcome of one decoded branch operation in a small 32-bit in-order core. Each operation arrives with a kind code, a signed byte offset, a register operand value and its index, the address of the branch instruction, a condition-pass bit from the flag evaluator and the current condition flags. One clock edge later the unit presents a registered result. The result holds the taken strobe, the target address, the link write enable and value, the execution-state bit, a fault request and an invalid-operand flag.

PC-relative kinds jump to the instruction address plus 4 plus the offset, and each kind has its own offset span. Register kinds jump to the register value with bit 0 cleared. That bit becomes the execution-state bit, and a clear bit 0 raises a fault in place of the branch. The call kinds write a return address with bit 0 set. The condition flags pass through the unit unchanged.

Top module: `brlink_unit`

## Requirements
- R1: Results appear on the clock edge after `in_valid` is sampled high, with `out_valid` high. An idle cycle gives `out_valid`, `out_taken`, `out_link_we`, `out_fault` and `out_invalid` all low. Synchronous reset clears those five strobes.
- R2: Kind codes 0 (relative jump) and 2 (relative call) with a legal offset assert `out_taken`, and `out_target` equals instruction address + 4 + offset.
- R3: Kind code 1 (conditional relative jump) is taken only when `in_cond_pass` is 1. When it is taken, the target follows the R2 formula. All other kinds ignore `in_cond_pass`.
- R4: Kind 2 sets `out_link_we` with link value (address + 4) with bit 0 forced to 1. Kind 4 (register call) sets `out_link_we` with link value (address + 2) with bit 0 forced to 1. Other kinds never write the link.
- R5: Kind codes 3 (register jump) and 4 set `out_target` to the register value with bit 0 cleared, and set `out_tstate` to register bit 0. Relative kinds give `out_tstate` = 1.
- R6: For kinds 3 and 4, a register value with bit 0 equal to 0 sets `out_fault`, and both `out_taken` and `out_link_we` stay low.
- R7: An offset is legal when it is even and lies within a span that depends on the kind. Kind 1 allows −256..+254. Kind 0 allows −2048..+2046. Kind 2 allows −16777216..+16777214. Any other offset sets `out_invalid`, and `out_taken` and `out_link_we` stay low.
- R8: For kinds 3 and 4, a register index of 13 or 15 sets `out_invalid` and blocks the branch and the link. Invalid takes precedence over fault, so `out_fault` stays low.
- R9: `out_flags` equals the `in_flags` value sampled with the operation.
- R10: Kind codes 5 to 7 set `out_invalid` and give no branch, link or fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_kind | input | 3 | Branch kind code |
| in_offset | input | 32 | Signed byte offset for relative kinds |
| in_rval | input | 32 | Register operand value |
| in_ridx | input | 4 | Register operand index |
| in_pc | input | 32 | Address of the branch instruction |
| in_cond_pass | input | 1 | Condition evaluated true |
| in_flags | input | 4 | Current condition flags |
| out_valid | output | 1 | Result present |
| out_taken | output | 1 | Branch taken |
| out_target | output | 32 | Branch target address |
| out_link_we | output | 1 | Link register write enable |
| out_link_val | output | 32 | Link register value |
| out_tstate | output | 1 | Execution-state bit |
| out_fault | output | 1 | Fault request |
| out_invalid | output | 1 | Invalid-operand flag |
| out_flags | output | 4 | Condition flags, unchanged |

## Verification
Every result of this unit passes through exactly one register. The strobes, the target, the link value, the state bit and the flags are therefore all due on the first rising edge after the operation is sampled. The bench drives each operation on a falling edge and reads the outputs on the next falling edge, half a period after the only edge that could update them. An idle falling-edge slot separates operations, and some slots check that the strobes drop. The target is compared only when the branch is taken. The state bit is compared only when the operand is valid.

// File: rtl/brlink_pkg.sv
package brlink_pkg;
  typedef enum logic [2:0] {
    BK_JUMP     = 3'd0,
    BK_JUMP_IF  = 3'd1,
    BK_CALL     = 3'd2,
    BK_REG      = 3'd3,
    BK_REG_CALL = 3'd4
  } br_kind_e;

  function automatic logic kind_is_reg(input logic [2:0] k);
    return (k == BK_REG) || (k == BK_REG_CALL);
  endfunction

  function automatic logic kind_is_rel(input logic [2:0] k);
    return (k == BK_JUMP) || (k == BK_JUMP_IF) || (k == BK_CALL);
  endfunction
endpackage

// File: rtl/brlink_span_check.sv
module brlink_span_check #(
  parameter int XLEN      = 32,
  parameter int SPAN_BITS = 12
) (
  input  logic [XLEN-1:0] off,
  output logic            ok
);
  localparam int HI_W = XLEN - SPAN_BITS + 1;

  logic [HI_W-1:0] hi;

  always_comb begin
    hi = off[XLEN-1:SPAN_BITS-1];
    // fits signed SPAN_BITS when sign extension bits agree; must be even
    ok = ((&hi) | ~(|hi)) & ~off[0];
  end
endmodule

// File: rtl/brlink_addr.sv
module brlink_addr #(
  parameter int XLEN       = 32,
  parameter int LONG_STEP  = 4,
  parameter int SHORT_STEP = 2
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] off,
  input  logic [XLEN-1:0] rval,
  output logic [XLEN-1:0] rel_tgt,
  output logic [XLEN-1:0] reg_tgt,
  output logic [XLEN-1:0] link_long,
  output logic [XLEN-1:0] link_short
);
  localparam logic [XLEN-1:0] STEP_L = XLEN'(LONG_STEP);
  localparam logic [XLEN-1:0] STEP_S = XLEN'(SHORT_STEP);

  logic [XLEN-1:0] pc_long;
  logic [XLEN-1:0] pc_short;

  always_comb begin
    pc_long    = pc + STEP_L;
    pc_short   = pc + STEP_S;
    rel_tgt    = pc_long + off;
    reg_tgt    = {rval[XLEN-1:1], 1'b0};
    link_long  = {pc_long[XLEN-1:1], 1'b1};
    link_short = {pc_short[XLEN-1:1], 1'b1};
  end
endmodule

// File: rtl/brlink_decide.sv
module brlink_decide
  import brlink_pkg::*;
#(
  parameter int RIDX_W = 4,
  parameter int SP_IDX = 13,
  parameter int PC_IDX = 15
) (
  input  logic [2:0]        kind,
  input  logic              cond_pass,
  input  logic              ok_cond,
  input  logic              ok_jump,
  input  logic              ok_call,
  input  logic [RIDX_W-1:0] ridx,
  input  logic              rbit0,
  output logic              taken,
  output logic              link_we,
  output logic              fault,
  output logic              invalid,
  output logic              use_reg,
  output logic              use_long
);
  localparam logic [RIDX_W-1:0] SP_CODE = RIDX_W'(SP_IDX);
  localparam logic [RIDX_W-1:0] PC_CODE = RIDX_W'(PC_IDX);

  logic bad_idx;
  logic span_ok;
  logic wants;
  logic links;

  always_comb begin
    use_reg  = kind_is_reg(kind);
    use_long = (kind == BK_CALL);
    bad_idx  = (ridx == SP_CODE) || (ridx == PC_CODE);
    span_ok  = 1'b0;
    wants    = 1'b1;
    links    = 1'b0;
    unique case (kind)
      BK_JUMP:     span_ok = ok_jump;
      BK_JUMP_IF:  begin span_ok = ok_cond; wants = cond_pass; end
      BK_CALL:     begin span_ok = ok_call; links = 1'b1; end
      BK_REG:      span_ok = ~bad_idx;
      BK_REG_CALL: begin span_ok = ~bad_idx; links = 1'b1; end
      default:     span_ok = 1'b0;
    endcase
    invalid = ~span_ok;
    fault   = span_ok & use_reg & ~rbit0;
    taken   = span_ok & ~fault & wants;
    link_we = span_ok & ~fault & links;
  end
endmodule

// File: rtl/brlink_unit.sv
module brlink_unit
  import brlink_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int RIDX_W     = 4,
  parameter int FLAG_W     = 4,
  parameter int COND_BITS  = 9,
  parameter int JUMP_BITS  = 12,
  parameter int CALL_BITS  = 25,
  parameter int SP_IDX     = 13,
  parameter int PC_IDX     = 15,
  parameter int LONG_STEP  = 4,
  parameter int SHORT_STEP = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        in_kind,
  input  logic [XLEN-1:0]   in_offset,
  input  logic [XLEN-1:0]   in_rval,
  input  logic [RIDX_W-1:0] in_ridx,
  input  logic [XLEN-1:0]   in_pc,
  input  logic              in_cond_pass,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  output logic              out_taken,
  output logic [XLEN-1:0]   out_target,
  output logic              out_link_we,
  output logic [XLEN-1:0]   out_link_val,
  output logic              out_tstate,
  output logic              out_fault,
  output logic              out_invalid,
  output logic [FLAG_W-1:0] out_flags
);
  localparam int NSPAN = 3;
  localparam int SPAN_W [NSPAN] = '{COND_BITS, JUMP_BITS, CALL_BITS};

  logic [NSPAN-1:0] span_ok;

  genvar g;
  generate
    for (g = 0; g < NSPAN; g++) begin : g_span
      brlink_span_check #(.XLEN(XLEN), .SPAN_BITS(SPAN_W[g])) u_span (
        .off (in_offset),
        .ok  (span_ok[g])
      );
    end
  endgenerate

  logic [XLEN-1:0] rel_tgt, reg_tgt, link_long, link_short;

  brlink_addr #(.XLEN(XLEN), .LONG_STEP(LONG_STEP), .SHORT_STEP(SHORT_STEP)) u_addr (
    .pc         (in_pc),
    .off        (in_offset),
    .rval       (in_rval),
    .rel_tgt    (rel_tgt),
    .reg_tgt    (reg_tgt),
    .link_long  (link_long),
    .link_short (link_short)
  );

  logic d_taken, d_link_we, d_fault, d_invalid, d_use_reg, d_use_long;

  brlink_decide #(.RIDX_W(RIDX_W), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX)) u_dec (
    .kind      (in_kind),
    .cond_pass (in_cond_pass),
    .ok_cond   (span_ok[0]),
    .ok_jump   (span_ok[1]),
    .ok_call   (span_ok[2]),
    .ridx      (in_ridx),
    .rbit0     (in_rval[0]),
    .taken     (d_taken),
    .link_we   (d_link_we),
    .fault     (d_fault),
    .invalid   (d_invalid),
    .use_reg   (d_use_reg),
    .use_long  (d_use_long)
  );

  // strobes: reset and qualified by the input valid
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_taken   <= 1'b0;
      out_link_we <= 1'b0;
      out_fault   <= 1'b0;
      out_invalid <= 1'b0;
    end else begin
      out_valid   <= in_valid;
      out_taken   <= in_valid & d_taken;
      out_link_we <= in_valid & d_link_we;
      out_fault   <= in_valid & d_fault;
      out_invalid <= in_valid & d_invalid;
    end
  end

  // data path: no reset, loads only with an operation
  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_target   <= d_use_reg ? reg_tgt : rel_tgt;
      out_link_val <= d_use_long ? link_long : link_short;
      out_tstate   <= d_use_reg ? in_rval[0] : 1'b1;
      out_flags    <= in_flags;
    end
  end
endmodule

// File: rtl/brlink_checker.sv
module brlink_checker #(
  parameter int XLEN   = 32,
  parameter int FLAG_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        in_kind,
  input logic [XLEN-1:0]   in_rval,
  input logic              in_cond_pass,
  input logic [FLAG_W-1:0] in_flags,
  input logic              out_valid,
  input logic              out_taken,
  input logic [XLEN-1:0]   out_target,
  input logic              out_link_we,
  input logic [XLEN-1:0]   out_link_val,
  input logic              out_fault,
  input logic              out_invalid,
  input logic [FLAG_W-1:0] out_flags
);
  p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_taken && !out_link_we && !out_fault && !out_invalid));
  p_cond_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind == 3'd1 && !in_cond_pass) |=> !out_taken);
  p_link_bit0_r4: assert property (@(posedge clk) disable iff (rst)
    out_link_we |-> out_link_val[0]);
  p_reg_target_even_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_kind == 3'd3 || in_kind == 3'd4)) |=> !out_target[0]);
  p_fault_blocks_r6: assert property (@(posedge clk) disable iff (rst)
    out_fault |-> (!out_taken && !out_link_we));
  p_reg_even_faults_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_kind == 3'd3 || in_kind == 3'd4) && !in_rval[0]) |=> (out_fault || out_invalid));
  p_invalid_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> (!out_taken && !out_link_we && !out_fault));
  p_flags_pass_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_flags == $past(in_flags)));
  p_bad_kind_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_kind > 3'd4) |=> out_invalid);
endmodule

bind brlink_unit brlink_checker #(.XLEN(XLEN), .FLAG_W(FLAG_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_kind      (in_kind),
  .in_rval      (in_rval),
  .in_cond_pass (in_cond_pass),
  .in_flags     (in_flags),
  .out_valid    (out_valid),
  .out_taken    (out_taken),
  .out_target   (out_target),
  .out_link_we  (out_link_we),
  .out_link_val (out_link_val),
  .out_fault    (out_fault),
  .out_invalid  (out_invalid),
  .out_flags    (out_flags)
);

// File: tb/brlink_unit_test.sv
`timescale 1ns/1ps
module brlink_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_kind = '0;
  logic [31:0] in_offset = '0;
  logic [31:0] in_rval = '0;
  logic [3:0]  in_ridx = '0;
  logic [31:0] in_pc = '0;
  logic        in_cond_pass = 1'b0;
  logic [3:0]  in_flags = '0;
  logic        out_valid, out_taken, out_link_we, out_tstate, out_fault, out_invalid;
  logic [31:0] out_target, out_link_val;
  logic [3:0]  out_flags;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  brlink_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind),
    .in_offset(in_offset), .in_rval(in_rval), .in_ridx(in_ridx), .in_pc(in_pc),
    .in_cond_pass(in_cond_pass), .in_flags(in_flags),
    .out_valid(out_valid), .out_taken(out_taken), .out_target(out_target),
    .out_link_we(out_link_we), .out_link_val(out_link_val), .out_tstate(out_tstate),
    .out_fault(out_fault), .out_invalid(out_invalid), .out_flags(out_flags)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected values, from the requirements
  logic        e_inv, e_fault, e_taken, e_lwe, e_ts;
  logic [31:0] e_tgt, e_lval;

  task automatic model(input int k, input int off, input logic [31:0] pc,
                       input logic [31:0] rv, input int idx, input bit cp);
    bit is_reg = (k == 3 || k == 4);
    int lo = 0, hi = -1;
    case (k)
      0: begin lo = -2048;     hi = 2046;     end
      1: begin lo = -256;      hi = 254;      end
      2: begin lo = -16777216; hi = 16777214; end
      default: ;
    endcase
    if (k > 4) e_inv = 1;
    else if (is_reg) e_inv = (idx == 13 || idx == 15);
    else e_inv = (off < lo) || (off > hi) || (off % 2 != 0);
    e_fault = !e_inv && is_reg && !rv[0];
    e_taken = !e_inv && !e_fault && (k != 1 || cp);
    e_lwe   = !e_inv && !e_fault && (k == 2 || k == 4);
    e_tgt   = is_reg ? (rv & 32'hFFFF_FFFE) : (pc + 32'd4 + 32'(off));
    e_lval  = (pc + ((k == 2) ? 32'd4 : 32'd2)) | 32'd1;
    e_ts    = is_reg ? rv[0] : 1'b1;
  endtask

  task automatic run(input int k, input int off, input logic [31:0] pc,
                     input logic [31:0] rv, input int idx, input bit cp, input logic [3:0] fl);
    @(negedge clk);
    in_valid = 1; in_kind = 3'(k); in_offset = 32'(off); in_pc = pc;
    in_rval = rv; in_ridx = 4'(idx); in_cond_pass = cp; in_flags = fl;
    model(k, off, pc, rv, idx, cp);
    @(negedge clk);
    in_valid = 0;
    chk(out_valid == 1'b1, "R1 valid", 32'(out_valid), 32'd1);
    chk(out_invalid == e_inv, "R7/R8/R10 invalid", 32'(out_invalid), 32'(e_inv));
    chk(out_fault == e_fault, "R6 fault", 32'(out_fault), 32'(e_fault));
    chk(out_taken == e_taken, "R2/R3 taken", 32'(out_taken), 32'(e_taken));
    chk(out_link_we == e_lwe, "R4 link_we", 32'(out_link_we), 32'(e_lwe));
    if (e_taken) chk(out_target == e_tgt, "R2/R5 target", out_target, e_tgt);
    if (e_lwe) chk(out_link_val == e_lval, "R4 link_val", out_link_val, e_lval);
    if (!e_inv) chk(out_tstate == e_ts, "R5 tstate", 32'(out_tstate), 32'(e_ts));
    chk(out_flags == fl, "R9 flags", 32'(out_flags), 32'(fl));
  endtask

  task automatic idle_check();
    @(negedge clk);
    in_valid = 0;
    in_kind = 3'd0;
    @(negedge clk);
    chk(!out_valid && !out_taken && !out_link_we && !out_fault && !out_invalid,
        "R1 idle strobes", {27'd0, out_valid, out_taken, out_link_we, out_fault, out_invalid}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!out_valid && !out_taken && !out_link_we && !out_fault && !out_invalid,
        "R1 reset strobes", {27'd0, out_valid, out_taken, out_link_we, out_fault, out_invalid}, 32'd0);
    rst = 0;

    // R2 relative jump / call spans
    run(0, 2046,  32'h0000_1000, 0, 0, 0, 4'h3);
    run(0, 2048,  32'h0000_1000, 0, 0, 0, 4'h3);
    run(0, -2048, 32'h0000_1000, 0, 0, 0, 4'h5);
    run(0, -2050, 32'h0000_1000, 0, 0, 0, 4'h5);
    run(2, 16777214,  32'h0100_0000, 0, 0, 0, 4'h9);
    run(2, 16777216,  32'h0100_0000, 0, 0, 0, 4'h9);
    run(2, -16777216, 32'h0100_0000, 0, 0, 0, 4'hA);
    run(2, -16777218, 32'h0100_0000, 0, 0, 0, 4'hA);
    // R3 conditional, R7 edges
    run(1, 254,  32'h0000_2000, 0, 0, 1, 4'h1);
    run(1, 256,  32'h0000_2000, 0, 0, 1, 4'h1);
    run(1, -256, 32'h0000_2000, 0, 0, 1, 4'h2);
    run(1, -258, 32'h0000_2000, 0, 0, 1, 4'h2);
    run(1, 100,  32'h0000_2000, 0, 0, 0, 4'h4);
    run(0, 3,    32'h0000_2000, 0, 0, 0, 4'h4);
    run(0, 10,   32'h0000_2000, 0, 0, 0, 4'h4); // R3 cond_pass ignored (0)
    idle_check();
    // R5/R6/R8 register kinds
    run(3, 0, 32'h0000_3000, 32'h2000_0101, 1, 0, 4'h6);
    run(4, 0, 32'h0000_3002, 32'h2000_0201, 14, 0, 4'h6);
    run(3, 0, 32'h0000_3000, 32'h2000_0100, 2, 1, 4'h7);
    run(4, 0, 32'h0000_3000, 32'h2000_0100, 2, 1, 4'h7);
    run(3, 0, 32'h0000_3000, 32'h2000_0100, 13, 1, 4'h8);
    run(4, 0, 32'h0000_3000, 32'h2000_0101, 15, 1, 4'h8);
    // R10 undefined kinds
    run(5, 0, 32'h0000_4000, 32'h1, 0, 1, 4'hB);
    run(7, 0, 32'h0000_4000, 32'h1, 0, 1, 4'hC);
    idle_check();

    for (int i = 0; i < 600; i++) begin
      int k   = int'($urandom % 6);
      int sel = int'($urandom % 4);
      int off;
      case (sel)
        0: off = int'($urandom % 600) - 300;
        1: off = int'($urandom % 4200) - 2100;
        2: off = int'($urandom % 34000000) - 17000000;
        default: off = int'($urandom);
      endcase
      if ($urandom % 4 != 0) off = off & ~1;
      run(k, off, $urandom & 32'hFFFF_FFFE, $urandom, int'($urandom % 16),
          bit'($urandom % 2), 4'($urandom));
      if (i % 50 == 0) idle_check();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule